// File: doc/BRIEF.md
# Floating-Point Register Stack Pointer and Tag Manager

This block keeps the bookkeeping for an eight-register circular floating-point stack. It holds the 3-bit top-of-stack pointer, a 2-bit tag for each physical register and a small data array. Each cycle it can carry out one stack command: initialise, push, pop, exchange, free, free-then-pop, pointer increment or pointer decrement. It maps relative slot numbers to physical registers and packs all eight tags, in physical order, into a 16-bit tag word.

The surrounding unit sends a command with a relative slot number and, for a push, a value and a tag. It reads any slot through a combinational read port. It passes the status word through this block, which replaces the pointer field with the live pointer so every read of the status word sees the current value. A one-cycle stack-fault pulse reports a push onto an occupied register and a pop from an empty top.

Top module: `fpuStackMgr`

## Requirements
- R1: After reset, and in the cycle after an initialise command (cmdOp 0), the pointer is 0, the tag word is 0xFFFF and stackFault is 0. Tag codes are 00 valid, 01 zero, 10 special and 11 empty.
- R2: The read port addresses physical register (topPtr + rdSlot) mod 8. rdPhys gives that index, and rdData and rdTag give its contents.
- R3: Tag word bits [2i+1:2i] hold the tag of physical register i.
- R4: A push (cmdOp 1) decrements the pointer modulo 8. It then writes pushData and pushTag into the register at the new top, and the result is visible in the next cycle.
- R5: A pop (cmdOp 2) sets the tag of the old top to empty and increments the pointer modulo 8.
- R6: An exchange (cmdOp 3) swaps data and tag between slot 0 and slot cmdSlot. With cmdSlot 0 nothing changes.
- R7: A free (cmdOp 4) sets the tag of slot cmdSlot to empty and leaves the pointer and the data unchanged.
- R8: A free-then-pop (cmdOp 5) empties slot cmdSlot, then empties the old top and increments the pointer.
- R9: An increment (cmdOp 6) or decrement (cmdOp 7) of the pointer wraps modulo 8 and leaves every tag unchanged.
- R10: statusOut equals statusIn with bits [13:11] replaced by the current pointer, in the same cycle.
- R11: stackFault is high for exactly the one cycle after a push whose target tag was not empty, or after a pop whose top tag was empty. The command still takes effect.
- R12: While cmdValid is low, the pointer, the tags and the data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| cmdSlot | input | 3 | Relative slot operand |
| pushData | input | DATA_W | Value written by a push |
| pushTag | input | 2 | Tag written by a push |
| rdSlot | input | 3 | Relative slot for the read port |
| rdPhys | output | 3 | Physical index of rdSlot |
| rdData | output | DATA_W | Data of rdSlot |
| rdTag | output | 2 | Tag of rdSlot |
| topPtr | output | 3 | Top-of-stack pointer |
| tagWord | output | 16 | Packed tags of physical registers |
| statusIn | input | STATUS_W | Status word from outside |
| statusOut | output | STATUS_W | Status word with live pointer field |
| stackFault | output | 1 | One-cycle stack fault pulse |

## Verification
The main stimulus is a command sequence that fills the stack with three pushes carrying different tags. Each tag lands in a separate field of the tag word, so the checks can tell physical packing apart from relative packing. An exchange across distant slots shows whether data and tags move together. Frees and pops then drain the stack, and one pop lands on an already empty top, which must raise the fault without blocking the pointer move. Pointer steps through 7 and 0 catch wrap errors, and a push onto a re-occupied register triggers the push fault. Directed checks cover the pointer field insertion with all-zero and all-one status inputs, and the idle command line with a pop code applied.

// File: rtl/fpuStackPkg.sv
package fpuStackPkg;
  localparam int STACK_DEPTH = 8;
  localparam int PTR_W       = $clog2(STACK_DEPTH);
  localparam int TAG_W       = 2;
  localparam int TAGWORD_W   = STACK_DEPTH * TAG_W;

  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_XCHG    = 3'd3,
    OP_FREE    = 3'd4,
    OP_FREEPOP = 3'd5,
    OP_INC     = 3'd6,
    OP_DEC     = 3'd7
  } stackOpT;

  localparam logic [TAG_W-1:0] TAG_EMPTY = 2'b11;

  typedef struct packed {
    logic             clearAll;
    logic             loadEn;
    logic [PTR_W-1:0] loadIdx;
    logic             swapEn;
    logic [PTR_W-1:0] swapIdxA;
    logic [PTR_W-1:0] swapIdxB;
    logic             freeEnA;
    logic [PTR_W-1:0] freeIdxA;
    logic             freeEnB;
    logic [PTR_W-1:0] freeIdxB;
  } stackStrobeT;
endpackage

// File: rtl/fpuStackCtrl.sv
module fpuStackCtrl
  import fpuStackPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdOp,
  input  logic [PTR_W-1:0]      cmdSlot,
  input  logic [PTR_W-1:0]      rdSlot,
  input  logic [TAGWORD_W-1:0]  tagFlat,
  output logic [PTR_W-1:0]      topPtr,
  output logic [PTR_W-1:0]      rdIdx,
  output stackStrobeT           strobe,
  output logic                  stackFault
);
  logic [PTR_W-1:0] topQ, topD;
  logic [PTR_W-1:0] slotIdx, belowIdx, aboveIdx;
  logic             faultD, faultQ;
  stackOpT          opCode;

  function automatic logic [TAG_W-1:0] tagAt(input logic [PTR_W-1:0] idx);
    return tagFlat[{idx, 1'b0} +: TAG_W];
  endfunction

  assign opCode   = stackOpT'(cmdOp);
  assign slotIdx  = topQ + cmdSlot;
  assign belowIdx = topQ - 1'b1;
  assign aboveIdx = topQ + 1'b1;
  assign rdIdx    = topQ + rdSlot;

  always_comb begin
    strobe = '0;
    topD   = topQ;
    faultD = 1'b0;
    if (cmdValid) begin
      case (opCode)
        OP_INIT: begin
          strobe.clearAll = 1'b1;
          topD = '0;
        end
        OP_PUSH: begin
          topD           = belowIdx;
          strobe.loadEn  = 1'b1;
          strobe.loadIdx = belowIdx;
          faultD         = (tagAt(belowIdx) != TAG_EMPTY);
        end
        OP_POP: begin
          strobe.freeEnA  = 1'b1;
          strobe.freeIdxA = topQ;
          topD            = aboveIdx;
          faultD          = (tagAt(topQ) == TAG_EMPTY);
        end
        OP_XCHG: begin
          strobe.swapEn   = 1'b1;
          strobe.swapIdxA = topQ;
          strobe.swapIdxB = slotIdx;
        end
        OP_FREE: begin
          strobe.freeEnA  = 1'b1;
          strobe.freeIdxA = slotIdx;
        end
        OP_FREEPOP: begin
          strobe.freeEnA  = 1'b1;
          strobe.freeIdxA = slotIdx;
          strobe.freeEnB  = 1'b1;
          strobe.freeIdxB = topQ;
          topD            = aboveIdx;
        end
        OP_INC:  topD = aboveIdx;
        OP_DEC:  topD = belowIdx;
        default: topD = topQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ   <= '0;
      faultQ <= 1'b0;
    end else begin
      topQ   <= topD;
      faultQ <= faultD;
    end
  end

  assign topPtr     = topQ;
  assign stackFault = faultQ;
endmodule

// File: rtl/fpuStackData.sv
module fpuStackData
  import fpuStackPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  stackStrobeT           strobe,
  input  logic [DATA_W-1:0]     pushData,
  input  logic [TAG_W-1:0]      pushTag,
  input  logic [PTR_W-1:0]      rdIdx,
  output logic [TAGWORD_W-1:0]  tagFlat,
  output logic [DATA_W-1:0]     rdData,
  output logic [TAG_W-1:0]      rdTag
);
  logic [TAG_W-1:0]  tagQ  [STACK_DEPTH];
  logic [DATA_W-1:0] dataQ [STACK_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STACK_DEPTH; i++) begin
        tagQ[i]  <= TAG_EMPTY;
        dataQ[i] <= '0;
      end
    end else if (strobe.clearAll) begin
      for (int i = 0; i < STACK_DEPTH; i++) tagQ[i] <= TAG_EMPTY;
    end else begin
      for (int i = 0; i < STACK_DEPTH; i++) begin
        if (strobe.loadEn && strobe.loadIdx == PTR_W'(i)) begin
          tagQ[i]  <= pushTag;
          dataQ[i] <= pushData;
        end
        if (strobe.swapEn) begin
          if (strobe.swapIdxA == PTR_W'(i)) begin
            tagQ[i]  <= tagQ[strobe.swapIdxB];
            dataQ[i] <= dataQ[strobe.swapIdxB];
          end else if (strobe.swapIdxB == PTR_W'(i)) begin
            tagQ[i]  <= tagQ[strobe.swapIdxA];
            dataQ[i] <= dataQ[strobe.swapIdxA];
          end
        end
        if ((strobe.freeEnA && strobe.freeIdxA == PTR_W'(i)) ||
            (strobe.freeEnB && strobe.freeIdxB == PTR_W'(i)))
          tagQ[i] <= TAG_EMPTY;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < STACK_DEPTH; g++) begin : gPack
      assign tagFlat[g*TAG_W +: TAG_W] = tagQ[g];
    end
  endgenerate

  assign rdData = dataQ[rdIdx];
  assign rdTag  = tagQ[rdIdx];
endmodule

// File: rtl/fpuStackMgr.sv
module fpuStackMgr
  import fpuStackPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int STATUS_W = 16,
  parameter int TOP_LSB  = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdOp,
  input  logic [PTR_W-1:0]      cmdSlot,
  input  logic [DATA_W-1:0]     pushData,
  input  logic [TAG_W-1:0]      pushTag,
  input  logic [PTR_W-1:0]      rdSlot,
  output logic [PTR_W-1:0]      rdPhys,
  output logic [DATA_W-1:0]     rdData,
  output logic [TAG_W-1:0]      rdTag,
  output logic [PTR_W-1:0]      topPtr,
  output logic [TAGWORD_W-1:0]  tagWord,
  input  logic [STATUS_W-1:0]   statusIn,
  output logic [STATUS_W-1:0]   statusOut,
  output logic                  stackFault
);
  stackStrobeT strobe;

  fpuStackCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSlot(cmdSlot), .rdSlot(rdSlot), .tagFlat(tagWord),
    .topPtr(topPtr), .rdIdx(rdPhys), .strobe(strobe), .stackFault(stackFault)
  );

  fpuStackData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .pushTag(pushTag), .rdIdx(rdPhys), .tagFlat(tagWord),
    .rdData(rdData), .rdTag(rdTag)
  );

  always_comb begin
    statusOut = statusIn;
    statusOut[TOP_LSB +: PTR_W] = topPtr;
  end
endmodule

// File: rtl/fpuStackChk.sv
module fpuStackChk
  import fpuStackPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic [2:0]           cmdOp,
  input logic [PTR_W-1:0]     topPtr,
  input logic [TAGWORD_W-1:0] tagWord,
  input logic                 stackFault
);
  p_init_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd0) |=> (topPtr == '0 && tagWord == '1));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd2) |=> topPtr == PTR_W'($past(topPtr) + 1'b1));

  p_inc_keeps_tags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd6) |=>
      (topPtr == PTR_W'($past(topPtr) + 1'b1) && tagWord == $past(tagWord)));

  p_dec_keeps_tags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd7) |=>
      (topPtr == PTR_W'($past(topPtr) - 1'b1) && tagWord == $past(tagWord)));

  p_fault_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    stackFault |-> $past(cmdValid && (cmdOp == 3'd1 || cmdOp == 3'd2)));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ($stable(topPtr) && $stable(tagWord)));
endmodule

bind fpuStackMgr fpuStackChk uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .topPtr(topPtr), .tagWord(tagWord), .stackFault(stackFault)
);

// File: tb/fpuStackMgr_test.sv
module fpuStackMgr_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [2:0]  cmdSlot = '0;
  logic [15:0] pushData = '0;
  logic [1:0]  pushTag = '0;
  logic [2:0]  rdSlot = '0;
  logic [2:0]  rdPhys;
  logic [15:0] rdData;
  logic [1:0]  rdTag;
  logic [2:0]  topPtr;
  logic [15:0] tagWord;
  logic [15:0] statusIn = '0;
  logic [15:0] statusOut;
  logic        stackFault;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fpuStackMgr uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSlot(cmdSlot), .pushData(pushData), .pushTag(pushTag),
    .rdSlot(rdSlot), .rdPhys(rdPhys), .rdData(rdData), .rdTag(rdTag),
    .topPtr(topPtr), .tagWord(tagWord), .statusIn(statusIn),
    .statusOut(statusOut), .stackFault(stackFault)
  );

  // {valid, op, slot, data, tag, expTop, expTagWord, expSt0Data, expFault}
  localparam int NVEC = 15;
  localparam logic [60:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 3'd0, 16'h1111, 2'd0, 3'd7, 16'h3FFF, 16'h1111, 1'b0},
    {1'b1, 3'd1, 3'd0, 16'h2222, 2'd1, 3'd6, 16'h1FFF, 16'h2222, 1'b0},
    {1'b1, 3'd1, 3'd0, 16'h3333, 2'd2, 3'd5, 16'h1BFF, 16'h3333, 1'b0},
    {1'b1, 3'd3, 3'd2, 16'h0000, 2'd0, 3'd5, 16'h93FF, 16'h1111, 1'b0},
    {1'b1, 3'd7, 3'd0, 16'h0000, 2'd0, 3'd4, 16'h93FF, 16'h0000, 1'b0},
    {1'b1, 3'd6, 3'd0, 16'h0000, 2'd0, 3'd5, 16'h93FF, 16'h1111, 1'b0},
    {1'b1, 3'd4, 3'd1, 16'h0000, 2'd0, 3'd5, 16'hB3FF, 16'h1111, 1'b0},
    {1'b1, 3'd2, 3'd0, 16'h0000, 2'd0, 3'd6, 16'hBFFF, 16'h2222, 1'b0},
    {1'b1, 3'd2, 3'd0, 16'h0000, 2'd0, 3'd7, 16'hBFFF, 16'h3333, 1'b1},
    {1'b1, 3'd5, 3'd0, 16'h0000, 2'd0, 3'd0, 16'hFFFF, 16'h0000, 1'b0},
    {1'b1, 3'd7, 3'd0, 16'h0000, 2'd0, 3'd7, 16'hFFFF, 16'h3333, 1'b0},
    {1'b1, 3'd6, 3'd0, 16'h0000, 2'd0, 3'd0, 16'hFFFF, 16'h0000, 1'b0},
    {1'b1, 3'd1, 3'd0, 16'hAAAA, 2'd0, 3'd7, 16'h3FFF, 16'hAAAA, 1'b0},
    {1'b1, 3'd6, 3'd0, 16'h0000, 2'd0, 3'd0, 16'h3FFF, 16'h0000, 1'b0},
    {1'b1, 3'd1, 3'd0, 16'hBBBB, 2'd1, 3'd7, 16'h7FFF, 16'hBBBB, 1'b1}
  };

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd1: return "R4 push";
      3'd2: return "R5 pop";
      3'd3: return "R6 exchange";
      3'd4: return "R7 free";
      3'd5: return "R8 free-pop";
      3'd6: return "R9 increment";
      3'd7: return "R9 decrement";
      default: return "R1 init";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepCmd(input logic v, input logic [2:0] op, input logic [2:0] slot,
                         input logic [15:0] d, input logic [1:0] t);
    cmdValid = v; cmdOp = op; cmdSlot = slot; pushData = d; pushTag = t;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset top", 32'(topPtr), 32'd0);
    chk("R1 reset tag word", 32'(tagWord), 32'hFFFF);
    chk("R1 reset fault", 32'(stackFault), 32'd0);
    chk("R10 status at top 0", 32'(statusOut), 32'h0000);

    for (int k = 0; k < NVEC; k++) begin
      logic [60:0] e;
      e = VEC[k];
      rdSlot = 3'd0;
      stepCmd(e[60], e[59:57], e[56:54], e[53:38], e[37:36]);
      chk({reqOf(e[59:57]), " top"}, 32'(topPtr), 32'(e[35:33]));
      chk({reqOf(e[59:57]), " R3 tag word"}, 32'(tagWord), 32'(e[32:17]));
      chk({reqOf(e[59:57]), " R2 slot0 data"}, 32'(rdData), 32'(e[16:1]));
      chk({reqOf(e[59:57]), " R11 fault"}, 32'(stackFault), 32'(e[0]));
    end

    // R11 the fault lasts a single cycle; R12 a pop code with cmdValid low does nothing
    stepCmd(1'b0, 3'd2, 3'd0, 16'h0, 2'd0);
    chk("R11 fault drops", 32'(stackFault), 32'd0);
    chk("R12 idle top", 32'(topPtr), 32'd7);
    chk("R12 idle tag word", 32'(tagWord), 32'h7FFF);

    // R10 pointer field insertion, top = 7
    statusIn = 16'h0000; #1;
    chk("R10 status zeros", 32'(statusOut), 32'h3800);
    statusIn = 16'hFFFF; #1;
    chk("R10 status ones", 32'(statusOut), 32'hFFFF);

    // R2 relative mapping wraps past 7
    rdSlot = 3'd1; #1;
    chk("R2 phys of slot1", 32'(rdPhys), 32'd0);
    chk("R2 tag of slot1", 32'(rdTag), 32'd3);
    rdSlot = 3'd0; #1;
    chk("R2 tag of slot0", 32'(rdTag), 32'd1);

    // R6 exchange with slot 0 leaves everything in place
    stepCmd(1'b1, 3'd3, 3'd0, 16'h0, 2'd0);
    chk("R6 self exchange data", 32'(rdData), 32'hBBBB);
    chk("R6 self exchange tags", 32'(tagWord), 32'h7FFF);

    // R1 initialise command
    stepCmd(1'b1, 3'd0, 3'd0, 16'h0, 2'd0);
    chk("R1 init top", 32'(topPtr), 32'd0);
    chk("R1 init tag word", 32'(tagWord), 32'hFFFF);
    chk("R10 status ones at top 0", 32'(statusOut), 32'hC7FF);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule